// File: doc/BRIEF.md
# Multi-Lane DLL Bring-Up Sequencer

This block runs the power-up order for a memory PHY's delay-locked loops. The PHY has one master DLL and up to four byte-lane DLLs. A one-cycle `start` pulse samples a packed 32-bit phase word and a bus-width select. The block then steps every taking-part DLL through three timed stages. First the DLLs are held disabled with reset asserted. Next both disable and reset are dropped. Last the active-low reset is raised so the loops can lock. A one-cycle `done` pulse marks the end.

All stage waits are counted in pulses of a free-running microsecond tick, so the block is independent of the clock frequency. The master DLL and the active lanes move through each stage together and share one wait. A 16-bit bus uses only the lower half of the lanes. Lanes that take no part stay disabled and held in reset, and their phase stays zero. After `done`, the DLLs stay running until the next `start`.

Top module: `dll_bringup_seq`

## Requirements
- R1: After reset every DLL has disable = 1 and nreset = 0, all phase outputs are 0, and done is 0.
- R2: In the cycle after an accepted start, every DLL shows disable = 1 and nreset = 0. The master phase equals word bits [21:16]. Lane k (k = 0..3) takes word bits [4k+3:4k] when it is active, and 0 when it is not.
- R3: The hold stage ends on the second tick. In the cycle after that tick is sampled, the master and active lanes show disable = 0 and nreset = 0.
- R4: The release stage lasts 22 ticks. After the 22nd, the master and active lanes show disable = 0 and nreset = 1.
- R5: The run stage lasts 22 ticks. done is 1 for exactly the one cycle after the 22nd run tick is sampled, and 0 otherwise. The DLLs stay running after that.
- R6: The bus-width select is sampled at start. When it is 1, lanes 0 to 3 are active. When it is 0, only lanes 0 and 1 are active, and lanes 2 and 3 keep disable = 1, nreset = 0 and phase 0.
- R7: Clock cycles without a tick never advance a stage.
- R8: A start during the hold, release or run stage is ignored. It causes no restart, no reload of phase or width, and no change to the schedule.
- R9: A start after completion runs the whole sequence again with a newly sampled word and width.
- R10: No DLL ever has disable and nreset high at the same time.
- R11: The master DLL's disable and nreset always equal those of lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin the sequence |
| phase_word | input | 32 | Packed master and lane phase settings |
| bus_is_32bit | input | 1 | 1 selects four lanes, 0 selects two |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| mdll_disable | output | 1 | Master DLL disable |
| mdll_nreset | output | 1 | Master DLL active-low reset |
| mdll_phase | output | 6 | Master DLL phase |
| lane_disable | output | 4 | Per-lane DLL disable |
| lane_nreset | output | 4 | Per-lane DLL active-low reset |
| lane_phase | output | 16 | Per-lane phase, lane k at bits [4k+3:4k] |
| done | output | 1 | One-cycle pulse when the sequence completes |

## Verification
The hardest case to reach from the ports is a start that arrives in the middle of a stage. It has to be shown that this start neither reloads the latched phase word nor resets the partly counted wait. The stimulus injects a start with an inverted phase word between two ticks of the release stage. The bench then keeps counting the original 22-tick schedule, so a wrongly cleared counter would show up as a late stage change. Each run is repeated with back-to-back ticks and with idle cycles between ticks. This exposes any stage that advances on the clock rather than on the tick.

// File: rtl/dll_seq_pkg.sv
package dll_seq_pkg;
  typedef enum logic [2:0] {
    SEQ_IDLE    = 3'd0,
    SEQ_HOLD    = 3'd1,
    SEQ_RELEASE = 3'd2,
    SEQ_RUN     = 3'd3,
    SEQ_READY   = 3'd4
  } seq_state_e;
endpackage

// File: rtl/dll_rst_sync.sv
module dll_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/dll_tick_timer.sv
module dll_tick_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  // The stage ends on the tick that completes the programmed count.
  assign expire = en && tick && (cnt_q == (limit - CNT_W'(1)));

  always_comb begin
    cnt_d  = cnt_q;
    cnt_ce = 1'b0;
    if (!en) begin
      cnt_d  = '0;
      cnt_ce = (cnt_q != '0);
    end else if (tick) begin
      cnt_d  = expire ? '0 : cnt_q + CNT_W'(1);
      cnt_ce = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dll_seq_fsm.sv
module dll_seq_fsm
  import dll_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       step_expire,
  output seq_state_e state,
  output logic       load,
  output logic       busy,
  output logic       done
);
  seq_state_e state_q, state_d;
  logic       done_q, done_d;

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    done_d  = 1'b0;
    unique case (state_q)
      SEQ_IDLE, SEQ_READY: begin
        if (start) begin
          state_d = SEQ_HOLD;
          load    = 1'b1;
        end
      end
      SEQ_HOLD:    if (step_expire) state_d = SEQ_RELEASE;
      SEQ_RELEASE: if (step_expire) state_d = SEQ_RUN;
      SEQ_RUN: begin
        if (step_expire) begin
          state_d = SEQ_READY;
          done_d  = 1'b1;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  assign busy  = (state_q == SEQ_HOLD) || (state_q == SEQ_RELEASE) || (state_q == SEQ_RUN);
  assign state = state_q;
  assign done  = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end
endmodule

// File: rtl/dll_ctrl_decode.sv
module dll_ctrl_decode
  import dll_seq_pkg::*;
#(
  parameter int NUM_LANES    = 4,
  parameter int NARROW_LANES = 2
) (
  input  seq_state_e           state,
  input  logic                 wide,
  output logic                 mdll_disable,
  output logic                 mdll_nreset,
  output logic [NUM_LANES-1:0] lane_disable,
  output logic [NUM_LANES-1:0] lane_nreset
);
  // Control pair {disable, nreset} for one DLL given whether it takes part.
  function automatic logic [1:0] ctrl_pair(input seq_state_e st, input logic active);
    logic [1:0] pair;
    pair = 2'b10;
    if (active) begin
      unique case (st)
        SEQ_RELEASE:        pair = 2'b00;
        SEQ_RUN, SEQ_READY: pair = 2'b01;
        default:            pair = 2'b10;
      endcase
    end
    return pair;
  endfunction

  always_comb begin
    {mdll_disable, mdll_nreset} = ctrl_pair(state, 1'b1);
  end

  for (genvar gi = 0; gi < NUM_LANES; gi++) begin : g_lane
    logic lane_on;
    if (gi < NARROW_LANES) begin : g_always
      assign lane_on = 1'b1;
    end else begin : g_wide_only
      assign lane_on = wide;
    end
    always_comb begin
      {lane_disable[gi], lane_nreset[gi]} = ctrl_pair(state, lane_on);
    end
  end
endmodule

// File: rtl/dll_bringup_seq.sv
module dll_bringup_seq
  import dll_seq_pkg::*;
#(
  parameter int NUM_LANES       = 4,
  parameter int WORD_W          = 32,
  parameter int MST_PH_W        = 6,
  parameter int MST_PH_LSB      = 16,
  parameter int LANE_PH_W       = 4,
  parameter int WAIT_HOLD_US    = 2,
  parameter int WAIT_RELEASE_US = 22,
  parameter int WAIT_RUN_US     = 22
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic [WORD_W-1:0]              phase_word,
  input  logic                           bus_is_32bit,
  input  logic                           us_tick,
  output logic                           mdll_disable,
  output logic                           mdll_nreset,
  output logic [MST_PH_W-1:0]            mdll_phase,
  output logic [NUM_LANES-1:0]           lane_disable,
  output logic [NUM_LANES-1:0]           lane_nreset,
  output logic [NUM_LANES*LANE_PH_W-1:0] lane_phase,
  output logic                           done
);
  localparam int NARROW_LANES = NUM_LANES / 2;
  localparam int WAIT_MAX_A   = (WAIT_HOLD_US > WAIT_RELEASE_US) ? WAIT_HOLD_US : WAIT_RELEASE_US;
  localparam int WAIT_MAX     = (WAIT_MAX_A > WAIT_RUN_US) ? WAIT_MAX_A : WAIT_RUN_US;
  localparam int CNT_W        = $clog2(WAIT_MAX + 1);

  logic       rst_n_sync;
  seq_state_e state;
  logic       load, busy, step_expire;
  logic [CNT_W-1:0] step_limit;

  logic                           wide_q;
  logic [MST_PH_W-1:0]            mph_q, mph_d;
  logic [NUM_LANES*LANE_PH_W-1:0] lph_q, lph_d;
  logic                           unused_word_par;

  assign unused_word_par = ^phase_word;

  dll_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  dll_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .start       (start),
    .step_expire (step_expire),
    .state       (state),
    .load        (load),
    .busy        (busy),
    .done        (done)
  );

  always_comb begin
    unique case (state)
      SEQ_HOLD:    step_limit = CNT_W'(WAIT_HOLD_US);
      SEQ_RELEASE: step_limit = CNT_W'(WAIT_RELEASE_US);
      default:     step_limit = CNT_W'(WAIT_RUN_US);
    endcase
  end

  dll_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .en     (busy),
    .tick   (us_tick),
    .limit  (step_limit),
    .expire (step_expire)
  );

  // Phase fields taken from the packed word; inactive lanes load zero.
  always_comb begin
    mph_d = phase_word[MST_PH_LSB +: MST_PH_W];
  end

  for (genvar gl = 0; gl < NUM_LANES; gl++) begin : g_lph
    if (gl < NARROW_LANES) begin : g_low
      assign lph_d[gl*LANE_PH_W +: LANE_PH_W] = phase_word[gl*LANE_PH_W +: LANE_PH_W];
    end else begin : g_high
      assign lph_d[gl*LANE_PH_W +: LANE_PH_W] =
        bus_is_32bit ? phase_word[gl*LANE_PH_W +: LANE_PH_W] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      wide_q <= 1'b0;
      mph_q  <= '0;
      lph_q  <= '0;
    end else if (load) begin
      wide_q <= bus_is_32bit;
      mph_q  <= mph_d;
      lph_q  <= lph_d;
    end
  end

  dll_ctrl_decode #(
    .NUM_LANES    (NUM_LANES),
    .NARROW_LANES (NARROW_LANES)
  ) u_decode (
    .state        (state),
    .wide         (wide_q),
    .mdll_disable (mdll_disable),
    .mdll_nreset  (mdll_nreset),
    .lane_disable (lane_disable),
    .lane_nreset  (lane_nreset)
  );

  assign mdll_phase = mph_q;
  assign lane_phase = lph_q;
endmodule

// File: rtl/dll_bringup_seq_chk.sv
module dll_bringup_seq_chk #(
  parameter int NUM_LANES = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 mdll_disable,
  input logic                 mdll_nreset,
  input logic [NUM_LANES-1:0] lane_disable,
  input logic [NUM_LANES-1:0] lane_nreset,
  input logic                 done
);
  localparam int HALF = NUM_LANES / 2;

  a_r10_master_not_both: assert property (@(posedge clk) disable iff (!rst_n)
    mdll_disable |-> !mdll_nreset);

  a_r10_lanes_not_both: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_disable & lane_nreset) == '0);

  a_r11_master_matches_lane0: assert property (@(posedge clk) disable iff (!rst_n)
    (mdll_disable == lane_disable[0]) && (mdll_nreset == lane_nreset[0]));

  a_r5_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_done_while_running: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mdll_disable && mdll_nreset));

  a_r4_nreset_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdll_nreset) |-> $past(!mdll_disable));

  a_r3_enable_from_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdll_disable) |-> $past(!mdll_nreset));

  a_r6_upper_lanes_together: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_disable[NUM_LANES-1:HALF] == '0) || (lane_disable[NUM_LANES-1:HALF] == '1));
endmodule

bind dll_bringup_seq dll_bringup_seq_chk #(.NUM_LANES(NUM_LANES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mdll_disable (mdll_disable),
  .mdll_nreset  (mdll_nreset),
  .lane_disable (lane_disable),
  .lane_nreset  (lane_nreset),
  .done         (done)
);

// File: tb/dll_bringup_seq_bench.sv
module dll_bringup_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] phase_word;
  logic        bus_is_32bit;
  logic        us_tick;
  logic        mdll_disable, mdll_nreset, done;
  logic [5:0]  mdll_phase;
  logic [NL-1:0]   lane_disable, lane_nreset;
  logic [NL*4-1:0] lane_phase;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [31:0] cur_ph;
  logic        cur_wide;

  always #(CLK_PERIOD/2) clk = ~clk;

  dll_bringup_seq u_dll_bringup_seq (
    .clk (clk), .rst_n (rst_n), .start (start), .phase_word (phase_word),
    .bus_is_32bit (bus_is_32bit), .us_tick (us_tick),
    .mdll_disable (mdll_disable), .mdll_nreset (mdll_nreset), .mdll_phase (mdll_phase),
    .lane_disable (lane_disable), .lane_nreset (lane_nreset), .lane_phase (lane_phase),
    .done (done)
  );

  task automatic check_vec(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // st: 0 idle, 1 hold, 2 release, 3 run/ready
  task automatic check_state(input int st, input logic exp_done, input string req);
    logic [NL-1:0]   e_dis, e_nres;
    logic [NL*4-1:0] e_lph;
    logic [5:0]      e_mph;
    logic            m_dis, m_nres;
    m_dis  = (st <= 1);
    m_nres = (st == 3);
    e_mph  = (st == 0) ? 6'd0 : cur_ph[21:16];
    for (int k = 0; k < NL; k++) begin
      bit act;
      act = cur_wide || (k < NL/2);
      e_dis[k]  = act ? m_dis  : 1'b1;
      e_nres[k] = act ? m_nres : 1'b0;
      e_lph[k*4 +: 4] = (st != 0 && act) ? cur_ph[k*4 +: 4] : 4'd0;
    end
    check_vec({req, " ctrl"}, 64'({mdll_disable, mdll_nreset, lane_disable, lane_nreset}),
              64'({m_dis, m_nres, e_dis, e_nres}));
    check_vec("R2/R6 phase", 64'({mdll_phase, lane_phase}), 64'({e_mph, e_lph}));
    check_vec({req, " done"}, 64'(done), 64'(exp_done));
    check_vec("R10 never both", 64'((lane_disable & lane_nreset) | {3'b0, mdll_disable & mdll_nreset}), 64'(0));
    check_vec("R11 master eq lane0", 64'({mdll_disable, mdll_nreset}),
              64'({lane_disable[0], lane_nreset[0]}));
  endtask

  // One tick then `gap` idle cycles; check after the tick and in each idle cycle.
  task automatic tick_step(input int gap, input int st, input logic exp_done, input string req);
    us_tick = 1'b1;
    @(negedge clk);
    us_tick = 1'b0;
    check_state(st, exp_done, req);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      check_state(st, 1'b0, "R7 no tick no advance");
    end
  endtask

  task automatic run_seq(input logic [31:0] ph, input logic wide, input int gap, input bit inject);
    @(negedge clk);
    phase_word = ph; bus_is_32bit = wide; start = 1'b1;
    @(negedge clk);
    start = 1'b0; phase_word = ~ph; bus_is_32bit = ~wide;
    cur_ph = ph; cur_wide = wide;
    check_state(1, 1'b0, "R2 hold after start");
    for (int t = 1; t <= 2; t++)
      tick_step(gap, (t < 2) ? 1 : 2, 1'b0, (t < 2) ? "R3 hold wait" : "R3 release entry");
    for (int t = 1; t <= 22; t++) begin
      if (inject && t == 6) begin
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check_state(2, 1'b0, "R8 start ignored");
      end
      tick_step(gap, (t < 22) ? 2 : 3, 1'b0, (t < 22) ? "R4 release wait" : "R4 run entry");
    end
    for (int t = 1; t <= 22; t++)
      tick_step(0, 3, (t == 22), (t < 22) ? "R5 run wait" : "R5 done pulse");
    @(negedge clk);
    check_state(3, 1'b0, "R5 done clears, running");
  endtask

  initial begin
    logic [31:0] words [5];
    words[0] = 32'h0000_0000; words[1] = 32'hFFFF_FFFF; words[2] = 32'h003F_A5C3;
    words[3] = 32'h0015_1234; words[4] = 32'h002A_8765;
    rst_n = 1'b0; start = 1'b0; phase_word = 32'h0; bus_is_32bit = 1'b0; us_tick = 1'b0;
    cur_ph = 32'h0; cur_wide = 1'b0;
    repeat (3) @(negedge clk);
    check_state(0, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_state(0, 1'b0, "R1 after reset");
    // R9: repeated runs back to back with new words and widths.
    for (int w = 0; w < 5; w++)
      for (int b = 0; b < 2; b++)
        for (int g = 0; g < 3; g += 2)
          run_seq(words[w], b[0], g, (w % 2) == 0);
    check_state(3, 1'b0, "R9 final ready");
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule